// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Timing

This block is a master-only serial peripheral interface controller. It produces the serial clock and a single active-low chip-select. It moves 8-bit words in mode 0: the output data bit changes on the falling clock edge, the input bit is sampled on the rising edge, and the most significant bit goes first. The serial clock runs at the system clock divided by an even number, `2*cfg_half`.

A burst begins with a `start` pulse. The chip-select then stays asserted for `cfg_count` words. Each word is framed by a programmable setup interval and a programmable hold interval, both set by `cfg_tcs`. Each interval lasts `(2*cfg_tcs+1)*cfg_half` system cycles, which is 0.5, 1.5, 2.5 or 3.5 serial periods. Two words inside a burst are therefore never closer than one full serial period, and a larger `cfg_tcs` can only widen that gap.

Transmit words go into a one-word holding register through a valid/ready port. Received words come out through a valid/ready port. In normal mode the master waits before each word until a transmit word is present and the previous received word has been taken. In turbo mode it waits for neither. Under turbo it also clocks one look-ahead word beyond the requested count, and it re-sends the last transmit word whenever the holding register is empty.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: `mosi` carries the transmit word MSB first. It changes only while `sclk` is low and holds steady while `sclk` is high.
- R3: `miso` is sampled on each rising `sclk` edge, and the first sampled bit becomes bit 7. `rx_data` is presented with `rx_valid` = 1 after the eighth falling edge.
- R4: Each high phase of `sclk` lasts exactly `cfg_half` system cycles, and no low phase inside a burst is shorter than that.
- R5: The time from `cs_n` falling to the first rising edge is `(2*cfg_tcs+1)*cfg_half` cycles. The time from the last falling edge to `cs_n` rising is the same.
- R6: When data is ready, the time from the last falling edge of one word to the first rising edge of the next is `2*(2*cfg_tcs+1)*cfg_half` cycles. At `cfg_tcs` = 0 this is one serial period.
- R7: In normal mode (`cfg_turbo` = 0), exactly `cfg_count` words are clocked, and `cs_n` stays low across the whole burst.
- R8: In normal mode, if the holding register is empty between words, the master waits with `sclk` low and `cs_n` low. It clocks no word until new data is written, and it never repeats a word.
- R9: In normal mode, the next word does not start while a received word is still pending (`rx_valid` = 1 and `rx_ready` = 0).
- R10: In turbo mode, a burst clocks `cfg_count + 1` words without waiting for the consumer or for new data. The last transmit word is repeated whenever the holding register is empty.
- R11: A `start` pulse with `cfg_count` = 0 leaves `cs_n` high, and a `start` pulse during a burst has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | DIV_W | System cycles per serial half period (at least 1) |
| cfg_tcs | input | 2 | Chip-select setup/hold setting |
| cfg_turbo | input | 1 | Turbo mode enable |
| cfg_count | input | CNT_W | Words per burst |
| start | input | 1 | Begins a burst when idle |
| tx_data | input | 8 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | 8 | Received word |
| rx_valid | output | 1 | Received word pending |
| rx_ready | input | 1 | Consumer takes the received word |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip-select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle by the assertions: each high phase of `sclk` has exactly the divider's length, no low phase inside a burst is shorter, `mosi` holds while `sclk` is high, `sclk` never pulses outside chip-select, the bus stays idle without `start`, and a pending received word is never dropped. Other behaviour needs the bench's directed scenarios: the exact setup, hold and inter-word intervals for each `cfg_tcs`, the word counts in normal and turbo modes, the turbo repeat of the last transmit word, the mid-burst stall with no duplicate, and the waiting on an unconsumed received word.

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [1:0]       cfg_tcs,
  input  logic             cfg_turbo,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             start,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int TW = DIV_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_LEAD, S_BITS, S_TRAIL} st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [3:0]     edge_i;
  logic [CNT_W:0] left;
  logic [7:0]     sh, hold, last_tx;
  logic           hold_full, rbit;

  wire [TW-1:0] half_w   = TW'(cfg_half);
  wire [TW-1:0] side_len = TW'({cfg_tcs, 1'b1}) * half_w;
  wire          tmr_done = (tmr == '0);
  wire          rx_free  = !rx_valid || rx_ready;
  wire          can_go   = cfg_turbo || (hold_full && rx_free);
  wire          want     = (st == S_IDLE && start && cfg_count != '0) || (st == S_WAIT) ||
                           (st == S_TRAIL && tmr_done && left != (CNT_W+1)'(1));
  wire          launch   = want && can_go;
  wire          last_edge = (st == S_BITS) && tmr_done && (edge_i == 4'd15);
  wire [7:0]    next_word = hold_full ? hold : last_tx;

  assign tx_ready = !hold_full;
  assign cs_n     = (st == S_IDLE);
  assign mosi     = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      edge_i <= '0;
      left <= '0;
      sh <= '0;
      hold <= '0;
      last_tx <= '0;
      hold_full <= 1'b0;
      rbit <= 1'b0;
      sclk <= 1'b0;
      rx_data <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) begin
        hold <= tx_data;
        hold_full <= 1'b1;
      end
      if (launch && hold_full) hold_full <= 1'b0;

      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (last_edge) begin
        rx_valid <= 1'b1;
        rx_data <= {sh[6:0], rbit};
      end

      case (st)
        S_IDLE: if (start && cfg_count != '0) begin
          left <= (CNT_W+1)'(cfg_count) + (CNT_W+1)'(cfg_turbo);
          st <= S_WAIT;
        end
        S_LEAD: if (tmr_done) begin
          sclk <= 1'b1;
          rbit <= miso;
          edge_i <= 4'd1;
          tmr <= half_w - TW'(1);
          st <= S_BITS;
        end else tmr <= tmr - TW'(1);
        S_BITS: if (tmr_done) begin
          tmr <= half_w - TW'(1);
          edge_i <= edge_i + 4'd1;
          if (edge_i[0]) begin
            sclk <= 1'b0;
            if (edge_i == 4'd15) begin
              st <= S_TRAIL;
              tmr <= side_len - TW'(1);
            end else sh <= {sh[6:0], rbit};
          end else begin
            sclk <= 1'b1;
            rbit <= miso;
          end
        end else tmr <= tmr - TW'(1);
        S_TRAIL: if (tmr_done) begin
          left <= left - (CNT_W+1)'(1);
          st <= (left == (CNT_W+1)'(1)) ? S_IDLE : S_WAIT;
        end else tmr <= tmr - TW'(1);
        default: ;
      endcase

      if (launch) begin
        st <= S_LEAD;
        tmr <= side_len - TW'(1);
        sh <= next_word;
        last_tx <= next_word;
      end
    end
  end
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_half,
  input logic             cfg_turbo,
  input logic             start,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             sclk,
  input logic             cs_n,
  input logic             mosi
);
  logic [15:0] hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= sclk ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1) : 16'd0;
      lo_run <= (!sclk && !cs_n) ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1) : 16'd0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (cs_n && !sclk && tx_ready && !rx_valid));

  a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run == 16'(cfg_half)));

  a_r4_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (lo_run >= 16'(cfg_half)));

  a_r7_clock_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  a_r8_hold_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r9_rx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_turbo && rx_valid && !rx_ready) |=> rx_valid);

  a_r11_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !start) |=> cs_n);
endmodule

bind spi_cs_master spi_cs_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_turbo(cfg_turbo),
  .start(start), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/spi_cs_master_tb.sv
module spi_cs_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_half = 8'd2;
  logic [1:0] cfg_tcs = 2'd0;
  logic       cfg_turbo = 1'b0;
  logic [3:0] cfg_count = 4'd1;
  logic       start = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic       sclk, cs_n, mosi;
  logic       miso = 1'b0;

  spi_cs_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_tcs(cfg_tcs),
    .cfg_turbo(cfg_turbo), .cfg_count(cfg_count), .start(start),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic mon_clr = 1'b0;

  // Bus monitor and slave model
  logic [7:0] sdata [0:7];
  logic [7:0] words [0:7];
  logic [7:0] rxw [0:7];
  int rise_c [0:7];
  int fall_c [0:7];
  int nwords, bitn, nrx, cs_fall_c, cs_rise_c, last_rise, hi_min, hi_max;
  logic [7:0] sin;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_clr) begin
      nwords = 0; bitn = 0; nrx = 0; sin = 8'h00;
      cs_fall_c = -1; cs_rise_c = -1; hi_min = 99999; hi_max = 0; last_rise = 0;
    end else begin
      if (prev_cs && !cs_n) begin
        cs_fall_c = cyc;
        miso = sdata[0][7];
      end
      if (!prev_cs && cs_n) cs_rise_c = cyc;
      if (!prev_sclk && sclk) begin
        if (bitn == 0) rise_c[nwords & 7] = cyc;
        last_rise = cyc;
        sin = {sin[6:0], mosi};
        bitn = bitn + 1;
        if (bitn == 8) begin
          words[nwords & 7] = sin;
          nwords = nwords + 1;
          bitn = 0;
        end
      end
      if (prev_sclk && !sclk) begin
        if (cyc - last_rise < hi_min) hi_min = cyc - last_rise;
        if (cyc - last_rise > hi_max) hi_max = cyc - last_rise;
        if (bitn == 0 && nwords > 0) fall_c[(nwords - 1) & 7] = cyc;
        miso = sdata[nwords & 7][7 - bitn];
      end
      if (rx_valid && rx_ready) begin
        rxw[nrx & 7] = rx_data;
        nrx = nrx + 1;
      end
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual still running at cycle %0d, expected finish", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    for (int i = 0; i < 5000 && !tx_ready; i++) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && cs_rise_c < 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 20000 && nwords < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 tx_ready", int'(tx_ready), 1);
    check("R1 rx_valid", int'(rx_valid), 0);
  endtask

  task automatic t_single();
    cfg_half = 8'd2; cfg_tcs = 2'd0; cfg_turbo = 1'b0; cfg_count = 4'd1;
    sdata[0] = 8'h3C;
    clr();
    put(8'hA5);
    go();
    wait_idle();
    check("R2 mosi word", int'(words[0]), 'hA5);
    check("R3 rx word", int'(rxw[0]), 'h3C);
    check("R3 rx count", nrx, 1);
    check("R4 high min", hi_min, 2);
    check("R4 high max", hi_max, 2);
    check("R5 setup", rise_c[0] - cs_fall_c, 2);
    check("R5 hold", cs_rise_c - fall_c[0], 2);
    check("R7 words", nwords, 1);
  endtask

  task automatic t_tcs();
    cfg_half = 8'd3; cfg_tcs = 2'd3; cfg_turbo = 1'b0; cfg_count = 4'd2;
    sdata[0] = 8'h96; sdata[1] = 8'h0F;
    clr();
    put(8'h12);
    go();
    put(8'hE7);
    go();
    wait_idle();
    check("R5 setup tcs3", rise_c[0] - cs_fall_c, 21);
    check("R6 gap tcs3", rise_c[1] - fall_c[0], 42);
    check("R5 hold tcs3", cs_rise_c - fall_c[1], 21);
    check("R7 words", nwords, 2);
    check("R11 start while busy", nwords, 2);
    check("R2 word0", int'(words[0]), 'h12);
    check("R2 word1", int'(words[1]), 'hE7);
    check("R3 rx1", int'(rxw[1]), 'h0F);
    check("R4 high tcs3", hi_max, 3);
  endtask

  task automatic t_gap_min();
    cfg_half = 8'd1; cfg_tcs = 2'd0; cfg_turbo = 1'b0; cfg_count = 4'd3;
    clr();
    put(8'h01);
    go();
    put(8'h02);
    put(8'h03);
    wait_idle();
    check("R6 gap min w1", rise_c[1] - fall_c[0], 2);
    check("R6 gap min w2", rise_c[2] - fall_c[1], 2);
    check("R7 words3", nwords, 3);
    check("R2 word2", int'(words[2]), 'h03);
  endtask

  task automatic t_stall();
    cfg_half = 8'd2; cfg_tcs = 2'd1; cfg_turbo = 1'b0; cfg_count = 4'd2;
    clr();
    put(8'h5A);
    go();
    wait_words(1);
    repeat (60) @(negedge clk);
    check("R8 stall cs_n", int'(cs_n), 0);
    check("R8 stall sclk", int'(sclk), 0);
    check("R8 stall words", nwords, 1);
    put(8'hC3);
    wait_idle();
    check("R8 words after", nwords, 2);
    check("R8 no duplicate", int'(words[1]), 'hC3);
  endtask

  task automatic t_rx_hold();
    cfg_half = 8'd2; cfg_tcs = 2'd0; cfg_turbo = 1'b0; cfg_count = 4'd2;
    sdata[0] = 8'h44; sdata[1] = 8'h88;
    rx_ready = 1'b0;
    clr();
    put(8'hAA);
    go();
    put(8'h55);
    wait_words(1);
    repeat (60) @(negedge clk);
    check("R9 held words", nwords, 1);
    check("R9 rx pending", int'(rx_valid), 1);
    check("R9 rx data", int'(rx_data), 'h44);
    rx_ready = 1'b1;
    wait_idle();
    check("R9 words after", nwords, 2);
    check("R9 rx second", int'(rxw[1]), 'h88);
  endtask

  task automatic t_turbo();
    cfg_half = 8'd2; cfg_tcs = 2'd0; cfg_turbo = 1'b1; cfg_count = 4'd2;
    sdata[0] = 8'h11; sdata[1] = 8'h22; sdata[2] = 8'h33;
    clr();
    put(8'h81);
    go();
    wait_idle();
    check("R10 turbo words", nwords, 3);
    check("R10 turbo w1 repeat", int'(words[1]), 'h81);
    check("R10 turbo w2 repeat", int'(words[2]), 'h81);
    check("R10 turbo rx count", nrx, 3);
    check("R10 turbo rx extra", int'(rxw[2]), 'h33);
    cfg_turbo = 1'b0;
  endtask

  task automatic t_ignore();
    cfg_count = 4'd0;
    clr();
    go();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!cs_n) break;
    end
    check("R11 zero count cs_n", int'(cs_n), 1);
    check("R11 zero count words", nwords, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) sdata[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_tcs();
    t_gap_min();
    t_stall();
    t_rx_hold();
    t_turbo();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule